// File: doc/BRIEF.md
# EDO DRAM Module Controller

This block sits between a simple host request port and a 32-bit extended-data-out DRAM module. The module has two sides, each built from two 16-bit halves. The controller takes one word request at a time, drives the row and then the column on a shared 10-bit multiplexed address bus, and selects the side and half-word through four row strobes. It gates individual bytes through four column strobes. Every write is an early write, because the module's data pins serve both directions: the write enable is low before any column strobe falls.

A refresh timer requests a CAS-before-RAS cycle on all four strobe pairs at a fixed interval. A pending refresh wins over a new host request at the next idle point. An access that has already started always runs to the end. Every nanosecond limit is a parameter, and the controller rounds it up to whole clock cycles of the configured period.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The 20-bit word address is split into a row (bits 19:10) and a column (bits 9:0). The row is on the DRAM address bus when a row strobe falls. The column is on the bus when a column strobe falls.
- R2: Column strobe k (active low) gates byte lane k, which is data bits 8k+7:8k. A write strobes only the lanes whose byte enable is set. A read strobes all four lanes whatever the byte enables are.
- R3: Row strobe index 2h+s serves half-word h (0 = bits 15:0, 1 = bits 31:16) on side s. During an access, only the strobes of the selected side fall, and only for halves that have at least one strobed lane.
- R4: On a write, the write enable goes low and the write data is driven while every column strobe is still high. Both stay in place until the column strobes rise. On a read, the write enable stays high and the data output is not enabled.
- R5: Every row-strobe low period lasts at least ceil(T_RAS_NS/CLK_NS) cycles. Every precharge lasts at least ceil(T_RP_NS/CLK_NS) cycles. Every column-strobe low period lasts at least ceil(T_CAS_NS/CLK_NS) cycles.
- R6: A column strobe falls no earlier than ceil(T_RCD_NS/CLK_NS) cycles after the row strobe. Read data is captured no earlier than the row-strobe and column-strobe access times allow.
- R7: A refresh lowers all four column strobes, waits at least ceil(T_CSR_NS/CLK_NS) cycles, and then lowers all four row strobes. Refreshes recur once every ceil(T_REF_NS/CLK_NS) cycles.
- R8: A pending refresh is served before a new request, even while a request is held valid continuously. The ready output is high only when the controller is idle, no refresh is pending, and all strobes are high.
- R9: A completed read raises rd_valid_o for exactly one cycle, with the captured word on rd_data_o. A completed write raises wr_done_o for exactly one cycle.
- R10: While reset is asserted and right after it is released, all strobes are high, the write enable is high, the data output is disabled, both completion pulses are low and the ready output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_side_i | input | 1 | Module side select |
| req_be_i | input | 4 | Byte enables for writes |
| req_addr_i | input | 20 | Word address, row in upper 10 bits |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | One-cycle read completion |
| rd_data_o | output | 32 | Captured read word |
| wr_done_o | output | 1 | One-cycle write completion |
| dram_addr_o | output | 10 | Multiplexed row/column address |
| dram_ras_no | output | 4 | Row strobes, active low |
| dram_cas_no | output | 4 | Column strobes, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_dq_o | output | 32 | Data driven to the module |
| dram_dq_oe_o | output | 1 | Output enable for dram_dq_o |
| dram_dq_i | input | 32 | Data returned from the module |

## Verification
The hardest case to reach is a refresh falling due while the host keeps the request line high. Here the refresh has to slip in between two accesses and must never cut one short. The bench holds a read request valid for several refresh intervals with no gaps. It then counts the CAS-before-RAS events seen on the strobes, confirms that every streamed read still returns the correct word, and confirms that ready never rises while a strobe is low. Partial writes on both sides, with lanes left unwritten and then read back, show that lane and half-word gating keep the bytes apart.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACT, ST_CASL, ST_PRE, ST_RCAS, ST_RRAS, ST_RHOLD
  } edo_state_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_dly_cnt.sv
module edo_dly_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
  parameter int CYC = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int W = $clog2(CYC + 1);
  logic [W-1:0] cnt_q;
  logic         tick;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= W'(CYC - 1);
      pend_o <= 1'b0;
    end else begin
      cnt_q  <= tick ? W'(CYC - 1) : cnt_q - 1'b1;
      pend_o <= (pend_o & ~ack_i) | tick;
    end
  end
endmodule

// File: rtl/edo_lane_map.sv
module edo_lane_map #(
  parameter int LANES = 4
) (
  input  logic             side_i,
  input  logic [LANES-1:0] be_i,
  output logic [LANES-1:0] cas_n_o,
  output logic [3:0]       ras_n_o
);
  localparam int HALVES = 2;
  localparam int SIDES  = 2;
  localparam int LPH    = LANES / HALVES;

  assign cas_n_o = ~be_i;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic half_en;
    assign half_en = |be_i[h*LPH +: LPH];
    for (genvar s = 0; s < SIDES; s++) begin : g_side
      assign ras_n_o[h*SIDES + s] = ~(half_en && (side_i == 1'(s)));
    end
  end
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl import edo_pkg::*; #(
  parameter int ROW_W     = 10,
  parameter int LANES     = 4,
  parameter int CLK_NS    = 10,
  parameter int T_RAS_NS  = 60,
  parameter int T_RP_NS   = 40,
  parameter int T_RC_NS   = 104,
  parameter int T_CAS_NS  = 10,
  parameter int T_RAH_NS  = 10,
  parameter int T_RCD_NS  = 20,
  parameter int T_RAC_NS  = 60,
  parameter int T_CAC_NS  = 15,
  parameter int T_WCH_NS  = 10,
  parameter int T_CSR_NS  = 5,
  parameter int T_CHR_NS  = 10,
  parameter int T_REF_NS  = 15600
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_we_i,
  input  logic                 req_side_i,
  input  logic [LANES-1:0]     req_be_i,
  input  logic [2*ROW_W-1:0]   req_addr_i,
  input  logic [8*LANES-1:0]   req_wdata_i,
  output logic                 rd_valid_o,
  output logic [8*LANES-1:0]   rd_data_o,
  output logic                 wr_done_o,
  output logic [ROW_W-1:0]     dram_addr_o,
  output logic [3:0]           dram_ras_no,
  output logic [LANES-1:0]     dram_cas_no,
  output logic                 dram_we_no,
  output logic [8*LANES-1:0]   dram_dq_o,
  output logic                 dram_dq_oe_o,
  input  logic [8*LANES-1:0]   dram_dq_i
);
  localparam int ADDR_W = 2 * ROW_W;
  localparam int DATA_W = 8 * LANES;

  localparam int C_RAS = ns2cyc(T_RAS_NS, CLK_NS);
  localparam int C_RP  = ns2cyc(T_RP_NS,  CLK_NS);
  localparam int C_RC  = ns2cyc(T_RC_NS,  CLK_NS);
  localparam int C_CAS = ns2cyc(T_CAS_NS, CLK_NS);
  localparam int C_RAH = ns2cyc(T_RAH_NS, CLK_NS);
  localparam int C_RCD = ns2cyc(T_RCD_NS, CLK_NS);
  localparam int C_RAC = ns2cyc(T_RAC_NS, CLK_NS);
  localparam int C_CAC = ns2cyc(T_CAC_NS, CLK_NS);
  localparam int C_WCH = ns2cyc(T_WCH_NS, CLK_NS);
  localparam int C_CSR = ns2cyc(T_CSR_NS, CLK_NS);
  localparam int C_CHR = ns2cyc(T_CHR_NS, CLK_NS);
  localparam int C_REF = ns2cyc(T_REF_NS, CLK_NS);

  localparam int N_ACT   = imax(1, imax(C_RCD, C_RAH));
  localparam int N_CASL  = imax(imax(imax(1, C_CAS), imax(C_CAC, C_WCH)),
                                imax(C_RAS - N_ACT, C_RAC - N_ACT));
  localparam int N_PRE   = imax(imax(1, C_RP), C_RC - N_ACT - N_CASL);
  localparam int N_RCAS  = imax(1, C_CSR);
  localparam int N_RRAS  = imax(1, C_CHR);
  localparam int N_RHOLD = imax(1, C_RAS - N_RRAS);
  localparam int N_MAX   = imax(imax(imax(N_ACT, N_CASL), imax(N_PRE, N_RCAS)),
                                imax(N_RRAS, N_RHOLD));
  localparam int CNT_W   = $clog2(N_MAX + 1);

  edo_state_e state_q, nxt;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             cnt_zero, ref_pend, ref_ack, accept, cap;

  logic              lat_we_q, lat_side_q, lat_we_d, lat_side_d;
  logic [LANES-1:0]  lat_be_q, lat_be_d, be_eff_d;
  logic [ADDR_W-1:0] lat_addr_q, lat_addr_d;
  logic [DATA_W-1:0] lat_wdata_q, lat_wdata_d;
  logic [3:0]        map_ras_n;
  logic [LANES-1:0]  map_cas_n;

  logic [3:0]        ras_d;
  logic [LANES-1:0]  cas_d;
  logic              we_d, oe_d;
  logic [ROW_W-1:0]  addr_d;

  edo_dly_cnt #(.W(CNT_W)) u_dly (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(ld), .val_i(ld_val), .zero_o(cnt_zero)
  );

  edo_ref_timer #(.CYC(C_REF)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ref_ack), .pend_o(ref_pend)
  );

  assign req_ready_o = (state_q == ST_IDLE) && !ref_pend;
  assign accept      = req_valid_i && req_ready_o;
  assign ref_ack     = (state_q == ST_IDLE) && ref_pend;

  always_comb begin
    nxt = state_q; ld = 1'b0; ld_val = '0; cap = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (ref_pend) begin
                  nxt = ST_RCAS; ld = 1'b1; ld_val = CNT_W'(N_RCAS - 1);
                end else if (req_valid_i) nxt = ST_SETUP;
      ST_SETUP: begin nxt = ST_ACT; ld = 1'b1; ld_val = CNT_W'(N_ACT - 1); end
      ST_ACT:   if (cnt_zero) begin nxt = ST_CASL; ld = 1'b1; ld_val = CNT_W'(N_CASL - 1); end
      ST_CASL:  if (cnt_zero) begin
                  nxt = ST_PRE; ld = 1'b1; ld_val = CNT_W'(N_PRE - 1); cap = 1'b1;
                end
      ST_PRE:   if (cnt_zero) nxt = ST_IDLE;
      ST_RCAS:  if (cnt_zero) begin nxt = ST_RRAS; ld = 1'b1; ld_val = CNT_W'(N_RRAS - 1); end
      ST_RRAS:  if (cnt_zero) begin nxt = ST_RHOLD; ld = 1'b1; ld_val = CNT_W'(N_RHOLD - 1); end
      ST_RHOLD: if (cnt_zero) begin nxt = ST_PRE; ld = 1'b1; ld_val = CNT_W'(N_PRE - 1); end
      default:  nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    lat_we_d    = accept ? req_we_i    : lat_we_q;
    lat_side_d  = accept ? req_side_i  : lat_side_q;
    lat_be_d    = accept ? req_be_i    : lat_be_q;
    lat_addr_d  = accept ? req_addr_i  : lat_addr_q;
    lat_wdata_d = accept ? req_wdata_i : lat_wdata_q;
    be_eff_d    = lat_we_d ? lat_be_d : '1;  // reads strobe every lane
  end

  edo_lane_map #(.LANES(LANES)) u_map (
    .side_i(lat_side_d), .be_i(be_eff_d), .cas_n_o(map_cas_n), .ras_n_o(map_ras_n)
  );

  // strobes decoded from the next state and registered
  always_comb begin
    ras_d = '1; cas_d = '1; we_d = 1'b1; oe_d = 1'b0; addr_d = dram_addr_o;
    unique case (nxt)
      ST_SETUP: begin
        addr_d = lat_addr_d[ADDR_W-1:ROW_W]; we_d = ~lat_we_d; oe_d = lat_we_d;
      end
      ST_ACT: begin
        addr_d = lat_addr_d[ADDR_W-1:ROW_W]; we_d = ~lat_we_d; oe_d = lat_we_d;
        ras_d  = map_ras_n;
      end
      ST_CASL: begin
        addr_d = lat_addr_d[ROW_W-1:0]; we_d = ~lat_we_d; oe_d = lat_we_d;
        ras_d  = map_ras_n; cas_d = map_cas_n;
      end
      ST_RCAS:  cas_d = '0;
      ST_RRAS:  begin ras_d = '0; cas_d = '0; end
      ST_RHOLD: ras_d = '0;
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lat_we_q    <= 1'b0;
      lat_side_q  <= 1'b0;
      lat_be_q    <= '0;
      lat_addr_q  <= '0;
      lat_wdata_q <= '0;
      dram_ras_no <= '1;
      dram_cas_no <= '1;
      dram_we_no  <= 1'b1;
      dram_dq_oe_o <= 1'b0;
      dram_addr_o <= '0;
      dram_dq_o   <= '0;
      rd_data_o   <= '0;
      rd_valid_o  <= 1'b0;
      wr_done_o   <= 1'b0;
    end else begin
      state_q     <= nxt;
      lat_we_q    <= lat_we_d;
      lat_side_q  <= lat_side_d;
      lat_be_q    <= lat_be_d;
      lat_addr_q  <= lat_addr_d;
      lat_wdata_q <= lat_wdata_d;
      dram_ras_no <= ras_d;
      dram_cas_no <= cas_d;
      dram_we_no  <= we_d;
      dram_dq_oe_o <= oe_d;
      dram_addr_o <= addr_d;
      dram_dq_o   <= lat_wdata_d;
      rd_valid_o  <= cap && !lat_we_q;
      wr_done_o   <= cap && lat_we_q;
      if (cap && !lat_we_q) rd_data_o <= dram_dq_i;
    end
  end
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int N_RAS = 3,
  parameter int N_RP  = 2,
  parameter int N_RCD = 1,
  parameter int N_CSR = 1,
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             we_n,
  input logic             dq_oe,
  input logic             ready,
  input logic             rd_valid,
  input logic             wr_done
);
  localparam logic [15:0] L_RAS = 16'(N_RAS);
  localparam logic [15:0] L_RP  = 16'(N_RP);
  localparam logic [15:0] L_RCD = 16'(N_RCD);
  localparam logic [15:0] L_CSR = 16'(N_CSR);

  logic [15:0] lo_cnt, hi_cnt, cas_lo_cnt;
  logic        ras_hi, cas_hi;
  assign ras_hi = &ras_n;
  assign cas_hi = &cas_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0; hi_cnt <= L_RP; cas_lo_cnt <= '0;
    end else begin
      lo_cnt     <= ras_hi ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt     <= !ras_hi ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1);
      cas_lo_cnt <= (cas_n != '0) ? '0 :
                    ((cas_lo_cnt == '1) ? cas_lo_cnt : cas_lo_cnt + 1'b1);
    end
  end

  assert_ras_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_hi) |-> lo_cnt >= L_RAS);
  assert_ras_precharge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_hi) |-> hi_cnt >= L_RP);
  assert_ras_to_cas_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_hi) && !ras_hi) |-> lo_cnt >= L_RCD);
  assert_cbr_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_hi) && !cas_hi) |-> (cas_n == '0 && ras_n == '0 && cas_lo_cnt >= L_CSR));
  assert_we_fall_early_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n) |-> cas_hi);
  assert_we_rise_late_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n) |-> cas_hi);
  assert_oe_write_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe |-> !we_n);
  assert_ready_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready |-> (ras_hi && cas_hi));
  assert_rd_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid |=> !rd_valid);
  assert_wr_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done |=> !wr_done);
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
  .N_RAS(C_RAS), .N_RP(C_RP), .N_RCD(C_RCD), .N_CSR(C_CSR), .LANES(LANES)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ras_n   (dram_ras_no),
  .cas_n   (dram_cas_no),
  .we_n    (dram_we_no),
  .dq_oe   (dram_dq_oe_o),
  .ready   (req_ready_o),
  .rd_valid(rd_valid_o),
  .wr_done (wr_done_o)
);

// File: tb/test_edo_dram_ctrl.sv
module test_edo_dram_ctrl;
  localparam int CLK  = 20;
  localparam int REFN = 3000;
  localparam int REF_CYC = (REFN + CLK - 1) / CLK;
  localparam int MIN_LO  = (60 + CLK - 1) / CLK;
  localparam int MIN_HI  = (40 + CLK - 1) / CLK;
  localparam int MIN_RCD = (20 + CLK - 1) / CLK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_side = 1'b0;
  logic [3:0] req_be = '0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rd_valid, wr_done, dram_we_n, dram_dq_oe;
  logic [31:0] rd_data, dram_dq_o;
  logic [31:0] dq_in = '0;
  logic [9:0] dram_addr;
  logic [3:0] dram_ras_n, dram_cas_n;

  int checks = 0, errors = 0, cyc = 0;

  always #(CLK/2) clk = ~clk;

  edo_dram_ctrl #(.CLK_NS(CLK), .T_REF_NS(REFN)) i_edo_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_side_i(req_side), .req_be_i(req_be), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .wr_done_o(wr_done), .dram_addr_o(dram_addr), .dram_ras_no(dram_ras_n),
    .dram_cas_no(dram_cas_n), .dram_we_no(dram_we_n), .dram_dq_o(dram_dq_o),
    .dram_dq_oe_o(dram_dq_oe), .dram_dq_i(dq_in)
  );

  // behavioural module model and port monitor
  logic [7:0] mem [int];
  logic [9:0] row_lat [4];
  logic [3:0] prev_ras = '1, prev_cas = '1, ras_mask = '0, cas_mask = '0;
  logic prev_we = 1'b1, exp_we = 1'b0, seen_low = 1'b0;
  logic [9:0] last_row = '0, last_col = '0;
  int ref_cnt = 0, we_viol = 0, rdy_viol = 0;
  int lo_run = 0, hi_run = 0, rcd_run = 0;
  int min_lo = 1000, min_hi = 1000, min_rcd = 1000;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = '1; prev_cas = '1; prev_we = 1'b1;
    end else begin
      if (&prev_ras && dram_ras_n == 4'h0 && dram_cas_n == 4'h0) ref_cnt++;
      for (int i = 0; i < 4; i++)
        if (prev_ras[i] && !dram_ras_n[i] && &dram_cas_n) begin
          row_lat[i] = dram_addr; ras_mask[i] = 1'b1; last_row = dram_addr;
        end
      if (!(&dram_ras_n)) begin
        if (!(&prev_ras)) begin lo_run++; rcd_run++; end
        else begin
          if (seen_low && hi_run < min_hi) min_hi = hi_run;
          seen_low = 1'b1; lo_run = 1; rcd_run = 0;
        end
      end else begin
        if (!(&prev_ras)) begin
          if (lo_run < min_lo) min_lo = lo_run;
          hi_run = 1;
        end else hi_run++;
      end
      for (int k = 0; k < 4; k++)
        if (prev_cas[k] && !dram_cas_n[k] && !(&dram_ras_n)) begin
          int h, sd, key;
          h  = k / 2;
          sd = dram_ras_n[2*h+1] ? 0 : 1;
          key = (sd << 22) | (int'(row_lat[2*h+sd]) << 12) | (int'(dram_addr) << 2) | k;
          cas_mask[k] = 1'b1; last_col = dram_addr;
          if (rcd_run < min_rcd) min_rcd = rcd_run;
          if (dram_we_n != !exp_we) we_viol++;
          if (!dram_we_n) begin
            if (!dram_dq_oe) we_viol++;
            mem[key] = dram_dq_o[8*k +: 8];
          end else begin
            dq_in[8*k +: 8] = mem.exists(key) ? mem[key] : 8'hA5;
          end
        end
      if (dram_we_n != prev_we && !(&dram_cas_n)) we_viol++;
      if (req_ready && (!(&dram_ras_n) || !(&dram_cas_n))) rdy_viol++;
      prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_we = dram_we_n;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_ras(input logic we, input logic side, input logic [3:0] be);
    logic [3:0] b, r;
    b = we ? be : 4'hF;
    r = '0;
    if (|b[1:0]) r[side ? 1 : 0] = 1'b1;
    if (|b[3:2]) r[side ? 3 : 2] = 1'b1;
    return r;
  endfunction

  task automatic run_txn(input logic we, input logic side, input logic [3:0] be,
                         input logic [19:0] addr, input logic [31:0] wd,
                         output logic [31:0] rd, output bit done, output bit single);
    ras_mask = '0; cas_mask = '0; exp_we = we;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_side = side; req_be = be;
    req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    done = 1'b0; rd = '0;
    for (int i = 0; i < 100 && !done; i++) begin
      if (we ? wr_done : rd_valid) begin done = 1'b1; rd = rd_data; end
      else @(negedge clk);
    end
    @(negedge clk);
    single = !(rd_valid || wr_done);
  endtask

  // {we, side, be, addr, data}; read entries hold the expected word
  localparam int NV = 11;
  localparam logic [57:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'hF, 20'h00000, 32'h11223344},
    {1'b1, 1'b1, 4'hF, 20'h00000, 32'h55667788},
    {1'b1, 1'b0, 4'h3, 20'hFFFFF, 32'hAABBCCDD},
    {1'b1, 1'b0, 4'hC, 20'hFFFFF, 32'h99EE0000},
    {1'b0, 1'b0, 4'hF, 20'h00000, 32'h11223344},
    {1'b0, 1'b1, 4'hF, 20'h00000, 32'h55667788},
    {1'b0, 1'b0, 4'hF, 20'hFFFFF, 32'h99EECCDD},
    {1'b1, 1'b1, 4'h5, 20'h12345, 32'h01020304},
    {1'b0, 1'b1, 4'hF, 20'h12345, 32'hA502A504},
    {1'b1, 1'b0, 4'h8, 20'h00000, 32'hDE000000},
    {1'b0, 1'b0, 4'h0, 20'h00000, 32'hDE223344}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bit done, single;
    int r0, r1, pulses, bad;

    repeat (3) @(negedge clk);
    chk(dram_ras_n == 4'hF && dram_cas_n == 4'hF && dram_we_n && !dram_dq_oe,
        "R10 strobes in reset", {22'd0, dram_we_n, dram_dq_oe, dram_ras_n, dram_cas_n}, 32'h2FF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rd_valid && !wr_done && dram_ras_n == 4'hF && dram_cas_n == 4'hF,
        "R10 after release", {29'd0, req_ready, rd_valid, wr_done}, 32'h4);

    for (int v = 0; v < NV; v++) begin
      logic we, sd;
      logic [3:0] be;
      logic [19:0] ad;
      logic [31:0] dt;
      {we, sd, be, ad, dt} = VEC[v];
      run_txn(we, sd, be, ad, dt, rd, done, single);
      chk(done, "R9 completion seen", {31'd0, done}, 32'd1);
      chk(single, "R9 one-cycle pulse", {31'd0, single}, 32'd1);
      if (!we) chk(rd == dt, "R2 R3 read data", rd, dt);
      chk(cas_mask == (we ? be : 4'hF), "R2 lane strobes", {28'd0, cas_mask}, {28'd0, (we ? be : 4'hF)});
      chk(ras_mask == exp_ras(we, sd, be), "R3 row strobes", {28'd0, ras_mask}, {28'd0, exp_ras(we, sd, be)});
      if (v == 7) begin
        chk(last_row == 10'h048, "R1 row part", {22'd0, last_row}, 32'h48);
        chk(last_col == 10'h345, "R1 column part", {22'd0, last_col}, 32'h345);
      end
    end

    // R7: idle refresh cadence
    r0 = ref_cnt;
    repeat (500) @(negedge clk);
    r1 = ref_cnt - r0;
    chk(r1 >= 500 / REF_CYC && r1 <= 500 / REF_CYC + 1, "R7 refresh count while idle",
        r1, 500 / REF_CYC);

    // R8: request held valid across several refresh intervals
    r0 = ref_cnt; pulses = 0; bad = 0; exp_we = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_side = 1'b0; req_be = 4'hF; req_addr = 20'h00000;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rd_valid) begin
        pulses++;
        if (rd_data != 32'hDE223344) bad++;
      end
    end
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(ref_cnt - r0 >= 2, "R8 refresh served under continuous requests", ref_cnt - r0, 2);
    chk(pulses > 20, "R8 accesses continue between refreshes", pulses, 21);
    chk(bad == 0, "R8 streamed read data", bad, 0);
    chk(rdy_viol == 0, "R8 ready only when quiet", rdy_viol, 0);

    chk(we_viol == 0, "R4 early write and read enable", we_viol, 0);
    chk(min_lo >= MIN_LO, "R5 row strobe low width", min_lo, MIN_LO);
    chk(min_hi >= MIN_HI, "R5 precharge width", min_hi, MIN_HI);
    chk(min_rcd >= MIN_RCD, "R6 row to column delay", min_rcd, MIN_RCD);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule